// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block gathers the four interrupt causes of a UART receiver/transmitter pair into a single interrupt line and a 4-bit identification code that the CPU reads to learn which cause to service. The causes are receive line errors, receive data reaching a programmable fill threshold, a receive character timeout, and the transmit holding register running empty. Error, timeout and transmit-empty events reach the block as one-cycle pulses from the surrounding UART logic. Receive data availability is worked out here by comparing the receive FIFO count against a trigger threshold.

Each cause is latched or evaluated on its own and cleared by its own rule. A reading of the line status register clears the error flags. Receive-buffer activity clears the timeout. Data availability follows the FIFO count as a level. The transmit-empty cause clears on a transmit write, or on an identification read made while it is the cause being reported. A fixed priority encoder then picks the code to show. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification code is 4'b0001, the interrupt output is 0 and all four error flags are 0.
- R2: Only five identification codes ever appear: 4'b0001 (nothing pending), 4'b0110 (line error), 4'b0100 (data available), 4'b1100 (character timeout) and 4'b0010 (transmit empty).
- R3: Priority from highest to lowest is line error, then data available, then character timeout, then transmit empty. When data available and timeout are both pending, data available is reported.
- R4: An error pulse sets its flag on the next clock edge, and the flag stays set until it is cleared. Flag bit 0 is overrun, bit 1 is parity, bit 2 is framing and bit 3 is break. Any set flag raises the line error cause.
- R5: A line status read clears all four flags on the next edge. An error pulse that arrives in the same cycle as the read leaves its flag set.
- R6: Data available is pending exactly while the receive FIFO count is at or above the trigger level. The trigger select gives 1 character for 2'b00, 4 for 2'b01, 8 for 2'b10 and 14 for 2'b11.
- R7: A timeout pulse sets the timeout cause. A receive buffer read or a receive FIFO push clears it. If a clear and a timeout pulse arrive in the same cycle, the clear wins.
- R8: A transmit-empty pulse sets the transmit-empty cause, and a transmit holding write clears it. If the write and the pulse arrive in the same cycle, the write wins.
- R9: An identification read clears the transmit-empty cause only when 4'b0010 is the code being reported in that cycle. An identification read made while a higher-priority cause is shown leaves it pending.
- R10: The interrupt output is always the inverse of bit 0 of the identification code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_pulse | input | 4 | Error event pulses: [0] overrun, [1] parity, [2] framing, [3] break |
| lsr_rd | input | 1 | Line status register read strobe |
| rx_level | input | 5 | Current receive FIFO character count |
| trig_sel | input | 2 | Trigger level select (1/4/8/14 characters) |
| tmo_evt | input | 1 | Character timeout event pulse |
| rbr_rd | input | 1 | Receive buffer read strobe |
| rx_push | input | 1 | Receive FIFO write strobe |
| thre_evt | input | 1 | Transmit holding empty event pulse |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iir_rd | input | 1 | Identification register read strobe |
| irq | output | 1 | Interrupt request, active high |
| iid | output | 4 | Identification code |
| err_flags | output | 4 | Latched error flags |

## Verification
The threshold comparison is tested one count below and at the trigger for all four select values, which shows whether the threshold table is right and whether the comparison is `>=` or `>`. Several causes are stacked in pairs, and then the higher one is withdrawn, so each step of the priority order shows up separately, including data available over timeout. Colliding strobes in the same cycle (error with status read, timeout with buffer read, transmit-empty with transmit write) show which side of each clear rule wins. Identification reads are issued both while transmit empty is the code being reported and while it is hidden behind a line error, which tests the conditional clear.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_ERR = 4;

  typedef enum logic [3:0] {
    IID_NONE = 4'b0001,
    IID_LSR  = 4'b0110,
    IID_RDA  = 4'b0100,
    IID_CTO  = 4'b1100,
    IID_THRE = 4'b0010
  } iid_t;
endpackage

// File: rtl/uart_irq_errlatch.sv
// Sticky error flags: one set/clear cell per error kind; set beats clear.
module uart_irq_errlatch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags_o[g] <= 1'b0;
      else if (set_i[g])   flags_o[g] <= 1'b1;
      else if (clr_i)      flags_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_srcflags.sv
// Pending state for the timeout and transmit-empty causes.
module uart_irq_srcflags (
  input  logic clk,
  input  logic rst_n,
  input  logic tmo_set,
  input  logic tmo_clr,
  input  logic thre_set,
  input  logic thre_wr_clr,
  input  logic thre_id_clr,
  output logic tmo_o,
  output logic thre_o
);
  // Receive activity restarts the timer, so clear outranks a coincident set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tmo_o <= 1'b0;
    else if (tmo_clr) tmo_o <= 1'b0;
    else if (tmo_set) tmo_o <= 1'b1;
  end

  // A write refills the holding register; an id read only loses to a new set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           thre_o <= 1'b0;
    else if (thre_wr_clr) thre_o <= 1'b0;
    else if (thre_set)    thre_o <= 1'b1;
    else if (thre_id_clr) thre_o <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_prio.sv
// Fixed-priority encoder from pending causes to identification code.
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic lsr_act,
  input  logic rda_act,
  input  logic cto_act,
  input  logic thre_act,
  output iid_t iid_o
);
  always_comb begin
    if (lsr_act)       iid_o = IID_LSR;
    else if (rda_act)  iid_o = IID_RDA;
    else if (cto_act)  iid_o = IID_CTO;
    else if (thre_act) iid_o = IID_THRE;
    else               iid_o = IID_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int LEVEL_W = 5,
  parameter int TRIG_A  = 1,
  parameter int TRIG_B  = 4,
  parameter int TRIG_C  = 8,
  parameter int TRIG_D  = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         err_pulse,
  input  logic               lsr_rd,
  input  logic [LEVEL_W-1:0] rx_level,
  input  logic [1:0]         trig_sel,
  input  logic               tmo_evt,
  input  logic               rbr_rd,
  input  logic               rx_push,
  input  logic               thre_evt,
  input  logic               thr_wr,
  input  logic               iir_rd,
  output logic               irq,
  output logic [3:0]         iid,
  output logic [3:0]         err_flags
);
  logic [LEVEL_W-1:0] trig_lvl;
  logic               rda_act, tmo_q, thre_q, thre_shown;
  iid_t               iid_e;

  always_comb begin
    case (trig_sel)
      2'b00:   trig_lvl = LEVEL_W'(TRIG_A);
      2'b01:   trig_lvl = LEVEL_W'(TRIG_B);
      2'b10:   trig_lvl = LEVEL_W'(TRIG_C);
      default: trig_lvl = LEVEL_W'(TRIG_D);
    endcase
  end

  assign rda_act = (rx_level >= trig_lvl);

  uart_irq_errlatch #(.N(NUM_ERR)) i_err (
    .clk(clk), .rst_n(rst_n), .set_i(err_pulse), .clr_i(lsr_rd),
    .flags_o(err_flags)
  );

  assign thre_shown = (iid_e == IID_THRE);

  uart_irq_srcflags i_src (
    .clk(clk), .rst_n(rst_n),
    .tmo_set(tmo_evt), .tmo_clr(rbr_rd | rx_push),
    .thre_set(thre_evt), .thre_wr_clr(thr_wr),
    .thre_id_clr(iir_rd & thre_shown),
    .tmo_o(tmo_q), .thre_o(thre_q)
  );

  uart_irq_prio i_prio (
    .lsr_act(|err_flags), .rda_act(rda_act), .cto_act(tmo_q),
    .thre_act(thre_q), .iid_o(iid_e)
  );

  assign iid = iid_e;
  assign irq = ~iid_e[0];
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] err_pulse,
  input logic       lsr_rd,
  input logic       thr_wr,
  input logic       irq,
  input logic [3:0] iid,
  input logic [3:0] err_flags
);
  p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iid inside {4'b0001, 4'b0110, 4'b0100, 4'b1100, 4'b0010});

  p_irq_inverse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ~iid[0]);

  p_err_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags != 4'b0) |-> (iid == 4'b0110));

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse != 4'b0) |=> ((err_flags & $past(err_pulse)) == $past(err_pulse)));

  p_lsr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && err_pulse == 4'b0) |=> (err_flags == 4'b0));

  p_thr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (iid != 4'b0010));
endmodule

bind uart_irq_ident uart_irq_ident_chk i_chk (
  .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .lsr_rd(lsr_rd),
  .thr_wr(thr_wr), .irq(irq), .iid(iid), .err_flags(err_flags)
);

// File: tb/test_uart_irq_ident.sv
`timescale 1ns/1ps
module test_uart_irq_ident;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] err_pulse = '0;
  logic       lsr_rd = 0, tmo_evt = 0, rbr_rd = 0, rx_push = 0;
  logic       thre_evt = 0, thr_wr = 0, iir_rd = 0;
  logic [4:0] rx_level = '0;
  logic [1:0] trig_sel = '0;
  logic       irq;
  logic [3:0] iid, err_flags;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  uart_irq_ident i_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .lsr_rd(lsr_rd),
    .rx_level(rx_level), .trig_sel(trig_sel), .tmo_evt(tmo_evt),
    .rbr_rd(rbr_rd), .rx_push(rx_push), .thre_evt(thre_evt),
    .thr_wr(thr_wr), .iir_rd(iir_rd), .irq(irq), .iid(iid),
    .err_flags(err_flags)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_iid(input string req, input logic [3:0] exp);
    chk(req, iid, exp);
    chk({req, " irq"}, {3'b0, irq}, {3'b0, ~exp[0]});
  endtask

  // Strobes are already driven; hold them one edge, then release.
  task automatic step();
    @(negedge clk);
    err_pulse = '0; lsr_rd = 0; tmo_evt = 0; rbr_rd = 0; rx_push = 0;
    thre_evt = 0; thr_wr = 0; iir_rd = 0;
  endtask

  task automatic t_reset();
    chk("R1 flags", err_flags, 4'b0000);
    chk_iid("R1 iid", 4'b0001);
  endtask

  task automatic t_errors();
    err_pulse = 4'b0010; step();
    chk("R4 parity flag", err_flags, 4'b0010);
    chk_iid("R4 line error code", 4'b0110);
    err_pulse = 4'b1001; step();
    chk("R4 accumulate", err_flags, 4'b1011);
    lsr_rd = 1; err_pulse = 4'b0100; step();
    chk("R5 same-cycle error kept", err_flags, 4'b0100);
    lsr_rd = 1; step();
    chk("R5 cleared", err_flags, 4'b0000);
    chk_iid("R5 idle", 4'b0001);
  endtask

  task automatic t_trigger();
    logic [4:0] lv [4] = '{5'd1, 5'd4, 5'd8, 5'd14};
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      rx_level = lv[s] - 5'd1; #1;
      chk_iid($sformatf("R6 below sel%0d", s), 4'b0001);
      rx_level = lv[s]; #1;
      chk_iid($sformatf("R6 at sel%0d", s), 4'b0100);
    end
    rx_level = 0; #1;
  endtask

  task automatic t_timeout();
    tmo_evt = 1; step();
    chk_iid("R7 set", 4'b1100);
    rbr_rd = 1; step();
    chk_iid("R7 rbr clear", 4'b0001);
    tmo_evt = 1; step();
    rx_push = 1; step();
    chk_iid("R7 push clear", 4'b0001);
    tmo_evt = 1; rbr_rd = 1; step();
    chk_iid("R7 clear wins", 4'b0001);
  endtask

  task automatic t_priority();
    trig_sel = 2'b01;
    tmo_evt = 1; thre_evt = 1; step();
    chk_iid("R3 timeout over thre", 4'b1100);
    rx_level = 5'd4; #1;
    chk_iid("R3 rda over timeout", 4'b0100);
    err_pulse = 4'b0001; step();
    chk_iid("R3 lsr over rda", 4'b0110);
    lsr_rd = 1; step();
    rx_level = 0; #1;
    chk_iid("R3 back to timeout", 4'b1100);
    rbr_rd = 1; step();
    chk_iid("R3 down to thre", 4'b0010);
    thr_wr = 1; step();
    chk_iid("R8 write clears", 4'b0001);
  endtask

  task automatic t_thre();
    thre_evt = 1; thr_wr = 1; step();
    chk_iid("R8 write wins", 4'b0001);
    thre_evt = 1; step();
    iir_rd = 1; step();
    chk_iid("R9 read clears shown", 4'b0001);
    thre_evt = 1; err_pulse = 4'b1000; step();
    chk_iid("R9 hidden", 4'b0110);
    iir_rd = 1; step();
    chk_iid("R9 read while hidden", 4'b0110);
    lsr_rd = 1; step();
    chk_iid("R9 still pending", 4'b0010);
    chk("R2 code legal", iid, 4'b0010);
    iir_rd = 1; step();
    chk_iid("R10 idle", 4'b0001);
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_errors();
    t_trigger();
    t_timeout();
    t_priority();
    t_thre();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule